// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two integer operands one multiplier bit per clock and returns the full double-width product. A single-cycle start pulse captures both operands and a signed/unsigned selector. The unit then runs a fixed number of shift-and-add steps, one for each operand bit, and raises a one-cycle done pulse once the product is ready.

In signed mode the operands are two's complement. The sign is handled inside the iteration itself, with no negation of the operands before the run and none of the result after it. Each step sign-extends the running partial sum. The partial product of the multiplier's top bit carries negative weight, so the last step subtracts the multiplicand where every other step adds it. In unsigned mode every step adds and the partial sum is zero-extended. Both modes always take the same number of cycles, whatever the operand values.

The block suits a processor integer unit that can stall on a multi-cycle multiply. The caller pulses start, waits for done, and reads the product. The product stays on the output until the next accepted start.

Top module: `iter_mul`

## Requirements
- R1: While reset is asserted, busy_o and done_o are 0 and product_o is all zeros.
- R2: With signed_i = 0 at start, the product equals the unsigned product of the two captured operands, as a 2*WIDTH-bit value (for example 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001).
- R3: With signed_i = 1 at start, the product equals the two's-complement product of the two captured operands, as a 2*WIDTH-bit value (for example 0x80000000 times 0x80000000 gives 0x4000000000000000).
- R4: done_o rises exactly WIDTH clock edges after the edge that accepts start, for any operands and either mode. busy_o is 1 from the edge after acceptance until done_o rises.
- R5: done_o is high for exactly one cycle per operation.
- R6: A start pulse while busy_o is 1 is ignored. Operand and mode inputs that change during a run have no effect on that run's product or timing.
- R7: While the unit is idle and start_i is 0, product_o holds its value, whatever the operand and mode inputs do.
- R8: Mode and operands are sampled only on the edge that accepts start (start_i = 1 while busy_o = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start_i | input | 1 | Start request, accepted only when idle |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | High while the iteration runs |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Full product, held until the next accepted start |

## Verification
A wrong add/subtract choice or a wrong extension bit shows up at the ports only as a bad product at the done pulse, WIDTH cycles after start. An error in the extension bit appears only when signs are mixed or bits sit near the top of the operands. For that reason a small WIDTH instance is swept over every operand pair in both modes, and the full-width corners are driven directly. A fault in the step counter shifts done_o away from its fixed slot, or widens it, and this is visible on the first operation. A capture path that leaks shows as a changed product during idle cycles, or as a product from operands that were never accepted.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;

endpackage

// File: rtl/iter_mul_rst_sync.sv
module iter_mul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  import iter_mul_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        state_d = ST_IDLE;
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/iter_mul_step.sv
module iter_mul_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             bit_i,
  input  logic             sgn_i,
  input  logic             last_i,
  output logic [WIDTH-1:0] hi_o,
  output logic             out_bit_o
);

  logic [WIDTH:0] acc_ext;
  logic [WIDTH:0] mc_ext;
  logic [WIDTH:0] addend;
  logic [WIDTH:0] sum;
  logic           negate;
  logic           carry_in;

  always_comb begin
    acc_ext  = {sgn_i & hi_i[WIDTH-1], hi_i};
    mc_ext   = {sgn_i & mcand_i[WIDTH-1], mcand_i};
    negate   = sgn_i && last_i;
    addend   = '0;
    carry_in = 1'b0;
    if (bit_i) begin
      addend   = negate ? ~mc_ext : mc_ext;
      carry_in = negate;
    end
    sum       = acc_ext + addend + {{WIDTH{1'b0}}, carry_in};
    hi_o      = sum[WIDTH:1];
    out_bit_o = sum[0];
  end

endmodule

// File: rtl/iter_mul.sv
module iter_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  import iter_mul_pkg::*;

  logic rst_sync_n;
  logic load, step, last;

  mul_mode_e        mode_q, mode_d;
  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [WIDTH-1:0] hi_q, hi_d;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic             regs_en;

  logic [WIDTH-1:0] step_hi;
  logic             step_bit;

  iter_mul_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iter_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  iter_mul_step #(.WIDTH(WIDTH)) u_step (
    .hi_i      (hi_q),
    .mcand_i   (mcand_q),
    .bit_i     (lo_q[0]),
    .sgn_i     (mode_q == MODE_SIGNED),
    .last_i    (last),
    .hi_o      (step_hi),
    .out_bit_o (step_bit)
  );

  always_comb begin
    mode_d  = mode_q;
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    regs_en = load || step;
    if (load) begin
      mode_d  = mul_mode_e'(signed_i);
      mcand_d = mcand_i;
      hi_d    = '0;
      lo_d    = mplier_i;
    end else if (step) begin
      hi_d = step_hi;
      if (WIDTH > 1) lo_d = {step_bit, lo_q[WIDTH-1:1]};
      else           lo_d = step_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= MODE_UNSIGNED;
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (regs_en) begin
      mode_q  <= mode_d;
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign product_o = {hi_q, lo_q};

endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               signed_i,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);

  localparam int RW = $clog2(WIDTH + 1) + 1;

  logic [WIDTH-1:0] cap_a, cap_b;
  logic             cap_s;
  logic [RW-1:0]    run_cnt;
  logic [2*WIDTH-1:0] exp_u, exp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      cap_s   <= 1'b0;
      run_cnt <= '0;
    end else if (start_i && !busy_o) begin
      cap_a   <= mcand_i;
      cap_b   <= mplier_i;
      cap_s   <= signed_i;
      run_cnt <= '0;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign exp_u = {{WIDTH{1'b0}}, cap_a} * {{WIDTH{1'b0}}, cap_b};
  assign exp_s = $signed({{WIDTH{cap_a[WIDTH-1]}}, cap_a}) *
                 $signed({{WIDTH{cap_b[WIDTH-1]}}, cap_b});

  // R1: reset holds outputs at zero
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!busy_o && !done_o && product_o == '0);
    end
  end

  p_unsigned_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_s) |-> (product_o == exp_u));

  p_signed_prod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_s) |-> (product_o == exp_s));

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == RW'(WIDTH)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < RW'(WIDTH)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  p_busy_excl_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

endmodule

bind iter_mul iter_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/tb_iter_mul.sv
`timescale 1ns/1ps
module tb_iter_mul;

  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          a_start, a_sgn;
  logic [W-1:0]  a_a, a_b;
  logic          a_busy, a_done;
  logic [2*W-1:0] a_prod;

  logic           s_start, s_sgn;
  logic [WS-1:0]  s_a, s_b;
  logic           s_busy, s_done;
  logic [2*WS-1:0] s_prod;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  iter_mul #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(a_start), .signed_i(a_sgn),
    .mcand_i(a_a), .mplier_i(a_b),
    .busy_o(a_busy), .done_o(a_done), .product_o(a_prod)
  );

  iter_mul #(.WIDTH(WS)) dut_small (
    .clk(clk), .rst_n(rst_n), .start_i(s_start), .signed_i(s_sgn),
    .mcand_i(s_a), .mplier_i(s_b),
    .busy_o(s_busy), .done_o(s_done), .product_o(s_prod)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp32(input logic [31:0] x, input logic [31:0] y,
                                        input logic sg);
    longint sx, sy;
    if (sg) begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      return 64'(sx * sy);
    end
    return {32'b0, x} * {32'b0, y};
  endfunction

  function automatic logic [7:0] exp4(input logic [3:0] x, input logic [3:0] y,
                                      input logic sg);
    int sx, sy;
    sx = sg ? int'($signed(x)) : int'(x);
    sy = sg ? int'($signed(y)) : int'(y);
    return 8'(sx * sy);
  endfunction

  // full-width operation with latency, busy, product and pulse checks
  task automatic run32(input logic [31:0] x, input logic [31:0] y, input logic sg);
    int n;
    logic [63:0] e;
    e = exp32(x, y, sg);
    @(negedge clk);
    a_start = 1'b1; a_a = x; a_b = y; a_sgn = sg;
    @(negedge clk);
    a_start = 1'b0;
    chk(a_busy == 1'b1, "R4 busy after start", 64'(a_busy), 64'd1);
    n = 1;
    while (!a_done && n < W + 5) begin
      @(negedge clk);
      n++;
    end
    chk(n == W + 1, "R4 latency", 64'(n), 64'(W + 1));
    chk(a_prod == e, sg ? "R3 signed product" : "R2 unsigned product", a_prod, e);
    @(negedge clk);
    chk(a_done == 1'b0, "R5 done single cycle", 64'(a_done), 64'd0);
  endtask

  task automatic run4(input logic [3:0] x, input logic [3:0] y, input logic sg);
    int n;
    logic [7:0] e;
    e = exp4(x, y, sg);
    @(negedge clk);
    s_start = 1'b1; s_a = x; s_b = y; s_sgn = sg;
    @(negedge clk);
    s_start = 1'b0;
    n = 1;
    while (!s_done && n < WS + 5) begin
      @(negedge clk);
      n++;
    end
    if (n != WS + 1) chk(1'b0, "R4 small latency", 64'(n), 64'(WS + 1));
    chk(s_prod == e, sg ? "R3 small signed sweep" : "R2 small unsigned sweep",
        64'(s_prod), 64'(e));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    int n;
    rst_n = 1'b0;
    a_start = 1'b0; a_sgn = 1'b0; a_a = '0; a_b = '0;
    s_start = 1'b0; s_sgn = 1'b0; s_a = '0; s_b = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!a_busy && !a_done && a_prod == '0, "R1 reset state",
        {a_prod[61:0], a_busy, a_done}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3 full-width corners
    run32(32'h8000_0000, 32'h8000_0000, 1'b1);
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run32(32'h8000_0000, 32'h0000_0001, 1'b1);
    run32(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
    run32(32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    run32(32'h0000_0000, 32'hDEAD_BEEF, 1'b1);
    run32(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    run32(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    run32(32'hFFFF_FFF9, 32'h0000_0002, 1'b1);

    // R6 / R8: restart and input changes during a run are ignored
    @(negedge clk);
    a_start = 1'b1; a_a = 32'd7; a_b = 32'd9; a_sgn = 1'b0;
    @(negedge clk);
    a_start = 1'b0;
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    a_start = 1'b1; a_a = 32'hFFFF; a_b = 32'hFFFF; a_sgn = 1'b1;
    @(negedge clk); n++;
    a_start = 1'b0; a_a = 32'h8000_0000; a_b = 32'h8000_0003;
    while (!a_done && n < W + 5) begin
      @(negedge clk);
      n++;
    end
    chk(n == W + 1, "R6 latency unchanged by restart", 64'(n), 64'(W + 1));
    chk(a_prod == 64'd63, "R8 product from captured operands", a_prod, 64'd63);

    // R7: idle hold while inputs wander
    held = a_prod;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      a_a = 32'(i * 37 + 5); a_b = ~a_a; a_sgn = ~a_sgn;
    end
    chk(a_prod == held && !a_busy, "R7 product held while idle", a_prod, held);

    // R2 / R3 exhaustive sweep on the small instance
    for (int sg = 0; sg < 2; sg++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run4(4'(x), 4'(y), 1'(sg));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule